// File: doc/BRIEF.md
# Programmable PIO Strobe Timing Sequencer

This block drives the host side of 8-bit register accesses on a parallel ATA-style disk bus. A requester presents an address, a direction bit and write data. The block then runs one access at a time through four phases: address setup, strobe, recovery and idle. During the access it drives the register address lines, one active-low strobe (read or write) and the data-bus output enable.

Three configuration fields set the access timing in clock cycles: the strobe width, the recovery gap after the strobe, and the write-data hold after the write strobe rises. Every field holds the wanted cycle count minus one. The write-data hold overlaps the start of recovery. On a read, the bus data is captured on the last strobe cycle. A one-cycle done pulse marks the point where recovery ends and the block is free again. Software picks field values so that strobe plus recovery meets the bus cycle-time minimum. The block adds no cycle-time floor of its own.

Top module: `pio_strobe_seq`

## Requirements
- R1: After a request is accepted, exactly one setup cycle passes with both strobes high. The strobe is then held low for exactly STB+1 cycles, where STB is the strobe-width field.
- R2: After the strobe rises, the recovery phase lasts RCV+1 cycles on reads. On writes it lasts the larger of RCV+1 and HLD+1 cycles. RCV is the recovery field and HLD is the hold field.
- R3: On writes, the output enable is high, and the data output holds the request's write data unchanged, from the setup cycle through HLD+1 cycles after the write strobe rises. The output enable is low at all other times, and it is never high on reads.
- R4: A field value of 0 yields a one-cycle phase, with no lower limit on any of the three fields.
- R5: On reads, the read-data output takes the bus input value present in the last strobe cycle. It keeps that value until the next read captures again.
- R6: A read (direction 0) lowers only the read strobe and a write (direction 1) lowers only the write strobe. The two strobes are never low together.
- R7: The done output is high for exactly one cycle: the first cycle after the recovery phase ends. A new request may be accepted in that cycle.
- R8: The address lines change only in the cycle after a request is accepted. They are stable through setup and strobe.
- R9: The ready output is high only when the block is idle. A request presented while ready is low is ignored.
- R10: The three timing fields are sampled when a request is accepted. Changes made during an access affect only later accesses.
- R11: During reset, both strobes are high, the output enable is low, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | Direction: 1 write, 0 read |
| req_addr | input | ADDR_W | Register address for the access |
| req_wdata | input | DATA_W | Write data |
| cfg_stb | input | STB_W | Strobe width minus one |
| cfg_rcv | input | RCV_W | Recovery length minus one |
| cfg_hld | input | HLD_W | Write-data hold minus one |
| req_ready | output | 1 | Idle; a request is accepted this cycle |
| done | output | 1 | One-cycle pulse when an access completes |
| rd_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Register address lines |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Data driven onto the bus |
| bus_oe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data from the bus |

## Verification
The bench builds the block with its default widths: a 5-bit strobe field, a 5-bit recovery field, a 3-bit hold field, 3 address bits and 8 data bits. With these widths, both extremes of every field can be reached: all-zero fields, which give the shortest possible access, and a 32-cycle strobe with 32 cycles of recovery. Hold values both above and below the recovery value are driven, so the hold-extends-recovery path and the overlap path both occur. The bus input changes every cycle, so a capture taken one cycle early or late gives a wrong value.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;
endpackage

// File: rtl/pio_phase_ctrl.sv
module pio_phase_ctrl
  import pio_seq_pkg::*;
#(
  parameter int STB_W = 5,
  parameter int RCV_W = 5,
  parameter int HLD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [STB_W-1:0] cfg_stb,
  input  logic [RCV_W-1:0] cfg_rcv,
  input  logic [HLD_W-1:0] cfg_hld,
  output phase_e           phase,
  output logic             ready,
  output logic             accept,
  output logic             last_strobe,
  output logic             hold_on,
  output logic             done
);
  localparam int RH_W  = (RCV_W > HLD_W) ? RCV_W : HLD_W;
  localparam int CNT_W = (STB_W > RH_W) ? STB_W : RH_W;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [STB_W-1:0]   stb_q;
  logic [RCV_W-1:0]   rcv_q;
  logic [HLD_W-1:0]   hld_q;
  logic               wr_q;
  logic               done_q, done_d;
  logic [CNT_W-1:0]   stb_x, rcv_x, hld_x, rec_end;
  logic               last_rec;

  // Zero-extend the latched fields to the counter width
  assign stb_x = CNT_W'(stb_q);
  assign rcv_x = CNT_W'(rcv_q);
  assign hld_x = CNT_W'(hld_q);

  // Writes keep recovery open until the data hold has also ended
  assign rec_end     = (wr_q && (hld_x > rcv_x)) ? hld_x : rcv_x;
  assign ready       = (phase_q == PH_IDLE);
  assign accept      = ready && req_valid;
  assign last_strobe = (phase_q == PH_STROBE) && (cnt_q == stb_x);
  assign last_rec    = (phase_q == PH_RECOV) && (cnt_q == rec_end);
  assign hold_on     = (phase_q == PH_RECOV) && wr_q && (cnt_q <= hld_x);
  assign phase       = phase_q;
  assign done        = done_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = last_rec;
    case (phase_q)
      PH_IDLE: begin
        if (accept) phase_d = PH_SETUP;
      end
      PH_SETUP: begin
        phase_d = PH_STROBE;
        cnt_d   = '0;
      end
      PH_STROBE: begin
        if (last_strobe) begin
          phase_d = PH_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_RECOV: begin
        if (last_rec) phase_d = PH_IDLE;
        else          cnt_d   = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // Timing fields are captured once per access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      rcv_q <= '0;
      hld_q <= '0;
      wr_q  <= 1'b0;
    end else if (accept) begin
      stb_q <= cfg_stb;
      rcv_q <= cfg_rcv;
      hld_q <= cfg_hld;
      wr_q  <= req_write;
    end
  end
endmodule

// File: rtl/pio_bus_drive.sv
module pio_bus_drive
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            phase,
  input  logic              last_strobe,
  input  logic              hold_on,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic              wr_q;
  logic              strobing, cap_en;

  assign strobing = (phase == PH_STROBE);
  assign cap_en   = last_strobe && !wr_q;

  assign bus_addr = addr_q;
  assign bus_dout = wdata_q;
  assign rd_data  = rd_q;
  assign bus_rd_n = !(strobing && !wr_q);
  assign bus_wr_n = !(strobing && wr_q);
  assign bus_oe   = wr_q && ((phase == PH_SETUP) || strobing || hold_on);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_en) rd_q <= bus_din;
  end
endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
  import pio_seq_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int STB_W  = 5,
  parameter int RCV_W  = 5,
  parameter int HLD_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STB_W-1:0]  cfg_stb,
  input  logic [RCV_W-1:0]  cfg_rcv,
  input  logic [HLD_W-1:0]  cfg_hld,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_din
);
  phase_e phase;
  logic   accept, last_strobe, hold_on;

  pio_phase_ctrl #(
    .STB_W(STB_W), .RCV_W(RCV_W), .HLD_W(HLD_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .cfg_stb     (cfg_stb),
    .cfg_rcv     (cfg_rcv),
    .cfg_hld     (cfg_hld),
    .phase       (phase),
    .ready       (req_ready),
    .accept      (accept),
    .last_strobe (last_strobe),
    .hold_on     (hold_on),
    .done        (done)
  );

  pio_bus_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .phase       (phase),
    .last_strobe (last_strobe),
    .hold_on     (hold_on),
    .bus_din     (bus_din),
    .bus_addr    (bus_addr),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_dout    (bus_dout),
    .bus_oe      (bus_oe),
    .rd_data     (rd_data)
  );
endmodule

// File: rtl/pio_strobe_seq_chk.sv
module pio_strobe_seq_chk #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int STB_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [STB_W-1:0]  cfg_stb,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd_n,
  input logic              bus_wr_n,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_oe
);
  logic             strobe_on;
  logic [STB_W:0]   len_q;
  logic [STB_W-1:0] stb_lat;

  assign strobe_on = !bus_rd_n || !bus_wr_n;

  // Count the cycles the strobe has been low so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         len_q <= '0;
    else if (strobe_on) len_q <= len_q + 1'b1;
    else                len_q <= '0;
  end

  // Record the strobe field seen at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stb_lat <= '0;
    else if (req_valid && req_ready) stb_lat <= cfg_stb;
  end

  a_r1_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_on && $past(strobe_on)) |-> (len_q == ({1'b0, stb_lat} + 1'b1)));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  a_r3_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);

  a_r3_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_dout));

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && $past(strobe_on)) |-> $stable(bus_addr));

  a_r9_busy_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> !req_ready);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind pio_strobe_seq pio_strobe_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STB_W(STB_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cfg_stb   (cfg_stb),
  .done      (done),
  .bus_addr  (bus_addr),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n),
  .bus_dout  (bus_dout),
  .bus_oe    (bus_oe)
);

// File: tb/pio_strobe_seq_bench.sv
module pio_strobe_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [2:0] req_addr;
  logic [7:0] req_wdata;
  logic [4:0] cfg_stb, cfg_rcv;
  logic [2:0] cfg_hld;
  logic       req_ready, done;
  logic [7:0] rd_data, bus_dout, bus_din;
  logic [2:0] bus_addr;
  logic       bus_rd_n, bus_wr_n, bus_oe;

  pio_strobe_seq u_pio_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_stb(cfg_stb),
    .cfg_rcv(cfg_rcv), .cfg_hld(cfg_hld), .req_ready(req_ready), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
  );

  typedef struct {
    logic       rd_n, wr_n, oe, done, ready, chk_rd;
    logic [2:0] addr;
    logic [7:0] dout, rd;
  } exp_t;

  exp_t   q[$];
  int     total = 0;
  int     bad = 0;
  int     cyc = 0;
  logic [2:0] last_addr = '0;
  string  ctx = "";

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s %s cycle=%0d actual=%0h expected=%0h", req, ctx, what, cyc, act, exp);
    end
  endtask

  // Advance one cycle and compare this cycle's outputs against the model
  task automatic step();
    exp_t e;
    @(negedge clk);
    cyc++;
    if (q.size() != 0) e = q.pop_front();
    else begin
      e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.done = 0; e.ready = 1;
      e.chk_rd = 0; e.addr = last_addr; e.dout = '0; e.rd = '0;
    end
    chk("R1", 32'(bus_rd_n), 32'(e.rd_n), "rd_n");
    chk("R6", 32'(bus_wr_n), 32'(e.wr_n), "wr_n");
    chk("R3", 32'(bus_oe), 32'(e.oe), "oe");
    if (e.oe) chk("R3", 32'(bus_dout), 32'(e.dout), "dout");
    chk("R8", 32'(bus_addr), 32'(e.addr), "addr");
    chk("R7", 32'(done), 32'(e.done), "done");
    chk("R9", 32'(req_ready), 32'(e.ready), "ready");
    if (e.chk_rd) chk("R5", 32'(rd_data), 32'(e.rd), "rd_data");
    bus_din = pat(cyc);
  endtask

  task automatic wait_idle();
    while (q.size() != 0) step();
  endtask

  // Present a request this cycle and queue the expected trace that follows
  task automatic issue(logic w, logic [2:0] a, logic [7:0] d,
                       int stb, int rcv, int hld);
    exp_t e;
    int   rec;
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    cfg_stb = 5'(stb); cfg_rcv = 5'(rcv); cfg_hld = 3'(hld);
    e.addr = a; e.dout = d; e.done = 0; e.ready = 0; e.chk_rd = 0; e.rd = '0;
    e.rd_n = 1; e.wr_n = 1; e.oe = w;
    q.push_back(e);
    for (int i = 0; i <= stb; i++) begin
      e.rd_n = w; e.wr_n = !w; e.oe = w;
      q.push_back(e);
    end
    rec = (w && hld > rcv) ? hld + 1 : rcv + 1;
    for (int i = 0; i < rec; i++) begin
      e.rd_n = 1; e.wr_n = 1; e.oe = w && (i <= hld);
      q.push_back(e);
    end
    e.oe = 0; e.done = 1; e.ready = 1; e.chk_rd = !w; e.rd = pat(cyc + 2 + stb);
    q.push_back(e);
    last_addr = a;
    step();
    req_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    cfg_stb = '0; cfg_rcv = '0; cfg_hld = '0; bus_din = '0;
    repeat (2) @(negedge clk);
    ctx = "R11";
    chk("R11", 32'(bus_rd_n), 32'd1, "reset rd_n");
    chk("R11", 32'(bus_wr_n), 32'd1, "reset wr_n");
    chk("R11", 32'(bus_oe), 32'd0, "reset oe");
    chk("R11", 32'(done), 32'd0, "reset done");
    chk("R11", 32'(req_ready), 32'd1, "reset ready");
    rst_n = 1;
    step(); step();

    ctx = "R4 zero read";  issue(0, 3'd1, 8'h00, 0, 0, 0); wait_idle();
    ctx = "R4 zero write"; issue(1, 3'd2, 8'hA5, 0, 0, 0); wait_idle();
    ctx = "R2 hold>rcv";   issue(1, 3'd3, 8'h3C, 2, 1, 5); wait_idle();
    ctx = "R2 hold<rcv";   issue(1, 3'd4, 8'hC3, 3, 6, 1); wait_idle();
    ctx = "R2 read ignores hold"; issue(0, 3'd5, 8'h00, 4, 1, 7); wait_idle();
    ctx = "R1 max read";   issue(0, 3'd6, 8'h00, 31, 31, 7); wait_idle();
    ctx = "R3 max hold";   issue(1, 3'd7, 8'h5A, 31, 0, 7); wait_idle();

    ctx = "R7 back-to-back";
    issue(0, 3'd1, 8'h00, 1, 0, 0); wait_idle();
    issue(1, 3'd2, 8'h81, 0, 2, 3); wait_idle();
    issue(0, 3'd3, 8'h00, 5, 0, 0); wait_idle();

    ctx = "R9 busy request";
    issue(0, 3'd4, 8'h00, 8, 3, 0);
    step();
    req_valid = 1; req_write = 1; req_addr = 3'd0; req_wdata = 8'hFF;
    step(); step();
    req_valid = 0;
    wait_idle();

    ctx = "R10 mid change";
    issue(1, 3'd5, 8'h66, 4, 2, 3);
    cfg_stb = 5'd20; cfg_rcv = 5'd15; cfg_hld = 3'd0;
    wait_idle();
    issue(0, 3'd6, 8'h00, 2, 4, 6);
    cfg_stb = 5'd0; cfg_rcv = 5'd0; cfg_hld = 3'd7;
    wait_idle();

    ctx = "R5 R6 random";
    for (int n = 0; n < 40; n++) begin
      issue(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
            8'($urandom_range(0, 255)), $urandom_range(0, 31),
            $urandom_range(0, 31), $urandom_range(0, 7));
      wait_idle();
      if (n % 5 == 0) begin step(); step(); end
    end

    step(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule